// File: doc/BRIEF.md
# Flash Thermometer-to-Binary Encoder

This block is the digital back end of an 8-bit flash converter. It takes the 255 comparator decisions of a resistor ladder as a thermometer vector. Bit 0 is the comparator nearest the bottom reference, and a decision of 1 means the input is above that tap. The block registers the vector on the sample clock and repairs isolated bubbles with a three-way majority vote at every position. It counts the surviving ones to form a binary code from 0 to 255. It then applies an output coding chosen by two polarity controls and registers the result.

The two polarity controls are independent. One flips only the most significant output bit and the other flips only the seven lower bits, which gives four codings:

- `MODE_STRAIGHT`: both controls low, straight binary.
- `MODE_LOW_FLIP`: only the low control high, lower seven bits complemented.
- `MODE_SIGN_FLIP`: only the high control high, offset binary turned into two's complement.
- `MODE_FULL_FLIP`: both controls high, fully complemented binary.

The polarity controls are captured on the same edge as the thermometer vector, so every output word is coded with the settings that were present when its sample was taken. A sample captured on clock edge N is visible on the output after edge N+1, and a new word follows on every edge.

Top module: `flash_therm_encoder`

## Requirements
- R1: While `rst` is high at a rising edge, `code_out` becomes the coding of code 0 under the live polarity inputs, which is {`inv_hi`, seven copies of `inv_lo`}.
- R2: With both polarity controls low, a clean thermometer with its k lowest bits set (0 ≤ k ≤ 255) produces `code_out` = k.
- R3: Inputs present at rising edge N appear on `code_out` after rising edge N+1. Samples applied on consecutive edges each produce their own output word on consecutive edges.
- R4: A single flipped bit whose two neighbours agree with its correct value is removed exactly. Below bit 0 there is an implied 1 and above bit 254 an implied 0.
- R5: A single flipped bit next to the 1/0 transition moves the code by exactly one step toward the flipped bit. A cleared top one gives k-1 and a set bottom zero gives k+1.
- R6: `inv_lo` high complements `code_out[6:0]` and leaves `code_out[7]` unchanged.
- R7: `inv_hi` high complements `code_out[7]` only. With both controls high, all eight bits are complemented.
- R8: Mid-scale sits at comparator 128: 127 set bits give 8'h7F and 128 set bits give 8'h80 in straight coding.
- R9: The polarity used for an output word is the one sampled on the same edge as its thermometer vector. A polarity change after that edge affects only later samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| therm_in | input | 255 | Comparator decisions, bit 0 = lowest tap, 1 = input above tap |
| inv_hi | input | 1 | Complement the most significant output bit |
| inv_lo | input | 1 | Complement the seven lower output bits |
| code_out | output | 8 | Registered output code |

## Verification
Every sample result is due two rising edges after the inputs are applied: one edge captures the inputs and the next loads the output register. Each directed task therefore drives on a falling edge, waits two rising edges, and compares on the following falling edge. The back-to-back task instead checks, on each falling edge, the word driven two falling edges earlier. Reset results are due after a single rising edge with `rst` high. The polarity-alignment task changes a control between the capture edge and the output edge and expects the old coding for that word.

// File: rtl/flash_enc_pkg.sv
package flash_enc_pkg;

    // Output coding selected by {inv_hi, inv_lo}
    typedef enum logic [1:0] {
        MODE_STRAIGHT  = 2'b00,
        MODE_LOW_FLIP  = 2'b01,
        MODE_SIGN_FLIP = 2'b10,
        MODE_FULL_FLIP = 2'b11
    } code_mode_t;

endpackage

// File: rtl/bubble_vote.sv
module bubble_vote #(
    parameter int TAPS = 255
) (
    input  logic [TAPS-1:0] raw,
    output logic [TAPS-1:0] fixed
);
    // Guard bits: an asserted tap below the ladder, a clear tap above it
    logic [TAPS+1:0] ext;
    assign ext = {1'b0, raw, 1'b1};

    for (genvar i = 0; i < TAPS; i++) begin : g_vote
        assign fixed[i] = (ext[i] & ext[i+1]) | (ext[i] & ext[i+2]) | (ext[i+1] & ext[i+2]);
    end

    // A well-formed thermometer has the form 0..01..1, so adding one leaves no overlap
    logic clean;
    assign clean = ((raw & (raw + 1'b1)) == '0);

    always_comb begin
        if (clean) begin
            AST_CLEAN_PASS: assert (fixed == raw); // R2
        end
    end
endmodule

// File: rtl/ones_counter.sv
module ones_counter #(
    parameter int TAPS = 255,
    parameter int CW   = 8
) (
    input  logic [TAPS-1:0] vec,
    output logic [CW-1:0]   cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < TAPS; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end

    always_comb begin
        if (vec == '0) begin
            AST_EMPTY_ZERO: assert (cnt == '0); // R2
        end
        if (&vec) begin
            AST_FULL_MAX: assert (cnt == CW'(TAPS)); // R2
        end
    end
endmodule

// File: rtl/code_polarity.sv
module code_polarity
    import flash_enc_pkg::*;
#(
    parameter int CW = 8
) (
    input  code_mode_t     mode,
    input  logic [CW-1:0]  bin,
    output logic [CW-1:0]  coded
);
    logic [CW-1:0] mask;

    always_comb begin
        unique case (mode)
            MODE_STRAIGHT:  mask = '0;
            MODE_LOW_FLIP:  mask = {1'b0, {(CW-1){1'b1}}};
            MODE_SIGN_FLIP: mask = {1'b1, {(CW-1){1'b0}}};
            MODE_FULL_FLIP: mask = '1;
            default:        mask = '0;
        endcase
    end

    assign coded = bin ^ mask;
endmodule

// File: rtl/flash_therm_encoder.sv
module flash_therm_encoder
    import flash_enc_pkg::*;
#(
    parameter int TAPS = 255
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [TAPS-1:0]               therm_in,
    input  logic                          inv_hi,
    input  logic                          inv_lo,
    output logic [$clog2(TAPS+1)-1:0]     code_out
);
    localparam int CW = $clog2(TAPS+1);

    // Capture stage: the thermometer and its polarity are taken together
    logic [TAPS-1:0] therm_q;
    code_mode_t      mode_q;

    always_ff @(posedge clk) begin
        therm_q <= therm_in;
        mode_q  <= code_mode_t'({inv_hi, inv_lo});
    end

    logic [TAPS-1:0] therm_fixed;
    logic [CW-1:0]   bin_code;
    logic [CW-1:0]   coded;
    logic [CW-1:0]   zero_coded;
    code_mode_t      live_mode;

    assign live_mode = code_mode_t'({inv_hi, inv_lo});

    bubble_vote #(.TAPS(TAPS)) u_vote (
        .raw   (therm_q),
        .fixed (therm_fixed)
    );

    ones_counter #(.TAPS(TAPS), .CW(CW)) u_count (
        .vec (therm_fixed),
        .cnt (bin_code)
    );

    code_polarity #(.CW(CW)) u_pol (
        .mode  (mode_q),
        .bin   (bin_code),
        .coded (coded)
    );

    // Code 0 under the polarity seen at the reset edge
    code_polarity #(.CW(CW)) u_rst_pol (
        .mode  (live_mode),
        .bin   ('0),
        .coded (zero_coded)
    );

    always_ff @(posedge clk) begin
        if (rst) code_out <= zero_coded;
        else     code_out <= coded;
    end

    // Edges since reset, used only to qualify the temporal checks
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)               age <= 2'd0;
        else if (age != 2'd3)  age <= age + 2'd1;
    end

    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && $past(therm_in, 2) == $past(therm_in, 3)
         && $past(inv_hi, 2) == $past(inv_hi, 3) && $past(inv_lo, 2) == $past(inv_lo, 3))
        |-> $stable(code_out)); // R3

    AST_LOW_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && $past(therm_in, 2) == $past(therm_in, 3)
         && $past(inv_hi, 2) == $past(inv_hi, 3) && $past(inv_lo, 2) != $past(inv_lo, 3))
        |-> (code_out[CW-2:0] == ~$past(code_out[CW-2:0]) && code_out[CW-1] == $past(code_out[CW-1]))); // R6

    AST_MSB_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && $past(therm_in, 2) == $past(therm_in, 3)
         && $past(inv_hi, 2) != $past(inv_hi, 3) && $past(inv_lo, 2) == $past(inv_lo, 3))
        |-> (code_out[CW-1] != $past(code_out[CW-1]) && code_out[CW-2:0] == $past(code_out[CW-2:0]))); // R7
endmodule

// File: tb/flash_therm_encoder_tb.sv
module flash_therm_encoder_tb;
    localparam int TAPS = 255;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [TAPS-1:0] therm_in = '0;
    logic            inv_hi = 1'b0;
    logic            inv_lo = 1'b0;
    logic [7:0]      code_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    flash_therm_encoder #(.TAPS(TAPS)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .therm_in (therm_in),
        .inv_hi   (inv_hi),
        .inv_lo   (inv_lo),
        .code_out (code_out)
    );

    function automatic logic [TAPS-1:0] therm(input int k);
        logic [TAPS-1:0] v;
        v = '0;
        for (int i = 0; i < k; i++) v[i] = 1'b1;
        return v;
    endfunction

    function automatic logic [7:0] enc(input int k, input logic hi, input logic lo);
        return 8'(k) ^ {hi, {7{lo}}};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: code_out=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive on a falling edge, capture edge, output edge, compare on a falling edge
    task automatic apply(input logic [TAPS-1:0] v, input logic hi, input logic lo);
        @(negedge clk);
        therm_in = v; inv_hi = hi; inv_lo = lo;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        for (int m = 0; m < 4; m++) begin
            @(negedge clk);
            rst = 1'b1; therm_in = therm(200);
            inv_hi = m[1]; inv_lo = m[0];
            @(posedge clk);
            @(negedge clk);
            check("R1", code_out, {m[1] == 1, {7{m[0] == 1}}});
        end
        @(negedge clk);
        rst = 1'b0; inv_hi = 1'b0; inv_lo = 1'b0;
    endtask

    task automatic t_sweep();
        for (int k = 0; k <= 255; k++) begin
            apply(therm(k), 1'b0, 1'b0);
            check("R2", code_out, 8'(k));
        end
    endtask

    task automatic t_midscale();
        apply(therm(127), 1'b0, 1'b0);
        check("R8", code_out, 8'h7F);
        apply(therm(128), 1'b0, 1'b0);
        check("R8", code_out, 8'h80);
    endtask

    task automatic t_polarity();
        int ks[4] = '{0, 77, 128, 255};
        foreach (ks[j]) begin
            apply(therm(ks[j]), 1'b0, 1'b1);
            check("R6", code_out, enc(ks[j], 1'b0, 1'b1));
            apply(therm(ks[j]), 1'b1, 1'b0);
            check("R7", code_out, enc(ks[j], 1'b1, 1'b0));
            apply(therm(ks[j]), 1'b1, 1'b1);
            check("R7", code_out, enc(ks[j], 1'b1, 1'b1));
        end
    endtask

    task automatic t_pipeline();
        int   ks[8] = '{5, 250, 0, 128, 127, 33, 255, 64};
        logic hs[8] = '{0, 1, 0, 1, 0, 0, 1, 1};
        logic ls[8] = '{0, 0, 1, 1, 0, 1, 0, 1};
        for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            if (j >= 2) check("R3", code_out, enc(ks[j-2], hs[j-2], ls[j-2]));
            if (j < 8) begin
                therm_in = therm(ks[j]); inv_hi = hs[j]; inv_lo = ls[j];
            end
        end
    endtask

    task automatic t_bubble();
        logic [TAPS-1:0] v;
        v = therm(100); v[40] = 1'b0;  apply(v, 0, 0); check("R4", code_out, 8'd100);
        v = therm(100); v[200] = 1'b1; apply(v, 0, 0); check("R4", code_out, 8'd100);
        v = therm(200); v[0] = 1'b0;   apply(v, 0, 0); check("R4", code_out, 8'd200);
        v = therm(10);  v[254] = 1'b1; apply(v, 0, 0); check("R4", code_out, 8'd10);
        v = therm(100); v[99] = 1'b0;  apply(v, 0, 0); check("R5", code_out, 8'd99);
        v = therm(100); v[100] = 1'b1; apply(v, 0, 0); check("R5", code_out, 8'd101);
        v = therm(255); v[254] = 1'b0; apply(v, 0, 0); check("R5", code_out, 8'd254);
    endtask

    task automatic t_align();
        @(negedge clk);
        therm_in = therm(90); inv_hi = 1'b0; inv_lo = 1'b0;
        @(posedge clk);           // capture with straight coding
        @(negedge clk);
        inv_lo = 1'b1; inv_hi = 1'b1;
        @(posedge clk);           // output of the first sample
        @(negedge clk);
        check("R9", code_out, enc(90, 1'b0, 1'b0));
        @(posedge clk);
        @(negedge clk);
        check("R9", code_out, enc(90, 1'b1, 1'b1));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_sweep();
        t_midscale();
        t_polarity();
        t_pipeline();
        t_bubble();
        t_align();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule